// File: doc/BRIEF.md
# Serial Address Recognition Filter

This block sits behind the asynchronous receiver of a multidrop serial link in which each frame carries eight payload bits and a ninth type bit. With filtering switched off, it delivers every frame it is given. With filtering on, it treats frames whose type bit is 1 as station addresses. It checks each one against two programmable bytes, an own-address byte and a care-mask byte. It then decides whether this station is being spoken to.

A station can be picked out in two ways. The first is its individual address, where only the bit positions set in the care mask are compared. The second is a group address derived as the OR of the two bytes, where any bit that is 1 in that pattern must also be 1 in the received byte. Once picked, the station accepts the data frames that follow. This lasts until an address frame arrives that does not pick it. Each delivered frame is placed in an output byte register, and a one-cycle receive pulse is raised with it.

Top module: `frame_addr_filter`

## Requirements
- R1: While reset is asserted and after it is released, the own-address and care-mask bytes are 00h, and `rxData`, `rxIrq` and `selected` are 0.
- R2: An address frame matches individually when, at every bit position where the care mask holds 1, the received bit equals the own-address bit. Positions where the mask holds 0 are ignored.
- R3: The group pattern is the OR of own-address and care mask. An address frame matches the group pattern when every bit that is 1 in the pattern is also 1 in the received byte. For example, with own-address F2h and mask FDh, FFh matches and FBh does not.
- R4: With filtering on, an address frame (type bit 1) that matches individually or by group sets `selected`. On the clock after the frame is sampled, its byte also appears on `rxData` with `rxIrq` high.
- R5: With filtering on, an address frame that matches neither way clears `selected`, raises no `rxIrq` and leaves `rxData` unchanged.
- R6: With filtering on and `selected` at 1, a data frame (type bit 0) is delivered on `rxData` with `rxIrq` high one clock later.
- R7: With filtering on and `selected` at 0, a data frame is dropped: no `rxIrq`, and `rxData` keeps its value.
- R8: With filtering off, every frame is delivered with `rxIrq`, whatever its type bit, and `selected` keeps its value.
- R9: A byte write (`regSel` 0 = own-address, 1 = care mask) is used only for frames sampled after the write edge. A frame in the same cycle as the write is judged against the old bytes, and `selected` is kept until the next address frame is judged.
- R10: With both bytes at 00h, every address frame matches.
- R11: `rxIrq` is high only in the cycle after a clock edge at which `frameValid` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe for the match bytes |
| regSel | input | 1 | 0 selects own-address, 1 selects care mask |
| regWrData | input | 8 | Byte to write |
| filterEn | input | 1 | 1 enables address filtering |
| frameValid | input | 1 | A received frame is present this cycle |
| frameData | input | 8 | Payload byte of the frame |
| frameTag | input | 1 | Ninth bit: 1 address frame, 0 data frame |
| rxData | output | 8 | Last delivered byte |
| rxIrq | output | 1 | One-cycle pulse per delivered frame |
| selected | output | 1 | Station currently picked by an address frame |

## Verification
Every result is due exactly one clock after the edge that samples the frame: `rxData`, `rxIrq` and `selected` are all registered once, with no other stage between. A byte write changes the matching from the edge after it, so a frame in the write cycle still sees the old bytes. The bench drives inputs at the falling edge and steps a behavioural model across the rising edge. It compares all three outputs 1 ns after every rising edge, so each comparison lands in the cycle the result is due.

// File: rtl/filt_pkg.sv
package filt_pkg;

  typedef enum logic {
    FRAME_DATA = 1'b0,
    FRAME_ADDR = 1'b1
  } frame_kind_e;

  typedef enum logic {
    SEL_OWN  = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic loadOut;
    logic writeOwn;
    logic writeMask;
  } ctrl_strobe_t;

endpackage

// File: rtl/filt_datapath.sv
module filt_datapath #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  filt_pkg::ctrl_strobe_t strobe,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic [DATA_W-1:0]     frameData,
  output logic                  givenHit,
  output logic                  bcastHit,
  output logic [DATA_W-1:0]     rxData
);

  logic [DATA_W-1:0] ownReg;
  logic [DATA_W-1:0] maskReg;
  logic [DATA_W-1:0] bcastPat;
  logic [DATA_W-1:0] givenBitOk;
  logic [DATA_W-1:0] bcastBitOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownReg  <= '0;
      maskReg <= '0;
    end else begin
      if (strobe.writeOwn)  ownReg  <= regWrData;
      if (strobe.writeMask) maskReg <= regWrData;
    end
  end

  assign bcastPat = ownReg | maskReg;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign givenBitOk[i] = !maskReg[i] || (frameData[i] == ownReg[i]);
    assign bcastBitOk[i] = !bcastPat[i] || frameData[i];
  end

  assign givenHit = &givenBitOk;
  assign bcastHit = &bcastBitOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rxData <= '0;
    else if (strobe.loadOut) rxData <= frameData;
  end

  a_r9_regs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.writeOwn || strobe.writeMask) |=> ($stable(ownReg) && $stable(maskReg)));

  a_r10_zero_regs_accept: assert property (@(posedge clk) disable iff (!rstN)
    (ownReg == '0 && maskReg == '0) |-> (givenHit && bcastHit));

endmodule

// File: rtl/filt_ctrl.sv
module filt_ctrl (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic                   regSel,
  input  logic                   filterEn,
  input  logic                   frameValid,
  input  logic                   frameTag,
  input  logic                   givenHit,
  input  logic                   bcastHit,
  output filt_pkg::ctrl_strobe_t strobe,
  output logic                   rxIrq,
  output logic                   selected
);
  import filt_pkg::*;

  logic isAddr;
  logic anyHit;
  logic deliver;
  logic selNext;

  assign isAddr = (frame_kind_e'(frameTag) == FRAME_ADDR);
  assign anyHit = givenHit || bcastHit;

  always_comb begin
    deliver = 1'b0;
    selNext = selected;
    if (frameValid) begin
      if (!filterEn) begin
        deliver = 1'b1;
      end else if (isAddr) begin
        deliver = anyHit;
        selNext = anyHit;
      end else begin
        deliver = selected;
      end
    end
  end

  always_comb begin
    strobe.loadOut   = deliver;
    strobe.writeOwn  = regWrEn && (reg_sel_e'(regSel) == SEL_OWN);
    strobe.writeMask = regWrEn && (reg_sel_e'(regSel) == SEL_MASK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxIrq    <= 1'b0;
      selected <= 1'b0;
    end else begin
      rxIrq    <= deliver;
      selected <= selNext;
    end
  end

  a_r11_irq_follows_valid: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> $past(frameValid));

  a_r4_hit_selects: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && filterEn && frameTag && (givenHit || bcastHit)) |=> (selected && rxIrq));

  a_r5_miss_clears: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && filterEn && frameTag && !givenHit && !bcastHit) |=> (!selected && !rxIrq));

  a_r6_data_when_selected: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && filterEn && !frameTag && selected) |=> (rxIrq && selected));

  a_r8_bypass_delivers: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !filterEn) |=> rxIrq);

endmodule

// File: rtl/frame_addr_filter.sv
module frame_addr_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              filterEn,
  input  logic              frameValid,
  input  logic [DATA_W-1:0] frameData,
  input  logic              frameTag,
  output logic [DATA_W-1:0] rxData,
  output logic              rxIrq,
  output logic              selected
);

  filt_pkg::ctrl_strobe_t strobe;
  logic givenHit;
  logic bcastHit;

  filt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .filterEn   (filterEn),
    .frameValid (frameValid),
    .frameTag   (frameTag),
    .givenHit   (givenHit),
    .bcastHit   (bcastHit),
    .strobe     (strobe),
    .rxIrq      (rxIrq),
    .selected   (selected)
  );

  filt_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWrData (regWrData),
    .frameData (frameData),
    .givenHit  (givenHit),
    .bcastHit  (bcastHit),
    .rxData    (rxData)
  );

  a_r7_drop_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && filterEn && !frameTag && !selected) |=> (!rxIrq && $stable(rxData)));

  a_r1_reset_outputs: assert property (@(posedge clk)
    !rstN |-> (rxData == '0 && !rxIrq && !selected));

endmodule

// File: tb/sim_frame_addr_filter.sv
`timescale 1ns/1ps
module sim_frame_addr_filter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] regWrData = '0;
  logic       filterEn = 1'b0;
  logic       frameValid = 1'b0;
  logic [7:0] frameData = '0;
  logic       frameTag = 1'b0;
  logic [7:0] rxData;
  logic       rxIrq;
  logic       selected;

  int checks = 0;
  int errors = 0;

  logic [7:0] mOwn = '0, mMask = '0, mData = '0;
  bit         mIrq = 0, mSel = 0;

  always #2 clk = ~clk;

  frame_addr_filter u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .filterEn(filterEn), .frameValid(frameValid),
    .frameData(frameData), .frameTag(frameTag), .rxData(rxData),
    .rxIrq(rxIrq), .selected(selected)
  );

  function automatic bit modelHit(input logic [7:0] b, input logic [7:0] own, input logic [7:0] msk);
    bit g = 1, c = 1;
    for (int i = 0; i < 8; i++) begin
      if (msk[i] && (b[i] != own[i])) g = 0;
      if ((own[i] || msk[i]) && !b[i]) c = 0;
    end
    return g || c;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (rxData !== mData || rxIrq !== mIrq || selected !== mSel) begin
      errors++;
      $display("FAIL %s: got data=%h irq=%b sel=%b expected data=%h irq=%b sel=%b",
               tag, rxData, rxIrq, selected, mData, mIrq, mSel);
    end
  endtask

  // Drive one cycle at the falling edge, step the model, compare after the rising edge.
  task automatic step(input string tag, input bit fv, input bit ft, input logic [7:0] fd,
                      input bit en, input bit we, input bit ws, input logic [7:0] wd);
    logic [7:0] nOwn, nMask, nData;
    bit nIrq, nSel, dlv;
    @(negedge clk);
    frameValid = fv; frameTag = ft; frameData = fd; filterEn = en;
    regWrEn = we; regSel = ws; regWrData = wd;
    nOwn = mOwn; nMask = mMask; nData = mData; nSel = mSel; dlv = 0;
    if (fv) begin
      if (!en) dlv = 1;
      else if (ft) begin
        nSel = modelHit(fd, mOwn, mMask);
        dlv = nSel;
      end else dlv = mSel;
    end
    if (dlv) nData = fd;
    nIrq = dlv;
    if (we) begin
      if (ws) nMask = wd; else nOwn = wd;
    end
    @(posedge clk);
    #1;
    mOwn = nOwn; mMask = nMask; mData = nData; mIrq = nIrq; mSel = nSel;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 8'h00, filterEn, 0, 0, 8'h00);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 compare("R1 in reset");
    @(negedge clk) rstN = 1'b1;
    idle("R1 after reset");

    // R10: zero bytes accept every address
    step("R10 addr 37h", 1, 1, 8'h37, 1, 0, 0, 0);
    step("R6 data while selected", 1, 0, 8'h55, 1, 0, 0, 0);
    step("R10 addr 00h", 1, 1, 8'h00, 1, 0, 0, 0);

    // R8: bypass mode
    step("R8 bypass data", 1, 0, 8'hA1, 0, 0, 0, 0);
    step("R8 bypass addr", 1, 1, 8'h3C, 0, 0, 0, 0);

    // R9: load own F1h and mask FAh
    step("R9 write own", 0, 0, 0, 1, 1, 0, 8'hF1);
    step("R9 write mask", 0, 0, 0, 1, 1, 1, 8'hFA);
    step("R2 given F0h accepted", 1, 1, 8'hF0, 1, 0, 0, 0);
    step("R6 data passes", 1, 0, 8'h12, 1, 0, 0, 0);
    step("R5 F3h rejected", 1, 1, 8'hF3, 1, 0, 0, 0);
    step("R7 data dropped", 1, 0, 8'h99, 1, 0, 0, 0);
    step("R3 broadcast FFh", 1, 1, 8'hFF, 1, 0, 0, 0);
    step("R3 broadcast FBh", 1, 1, 8'hFB, 1, 0, 0, 0);
    step("R2 given F8h rejected", 1, 1, 8'hF8, 1, 0, 0, 0);
    step("R7 data dropped again", 1, 0, 8'h77, 1, 0, 0, 0);

    // R3: own F2h mask FDh, broadcast is exactly FFh
    step("R9 write own F2", 0, 0, 0, 1, 1, 0, 8'hF2);
    step("R9 write mask FD", 0, 0, 0, 1, 1, 1, 8'hFD);
    step("R3 FBh rejected", 1, 1, 8'hFB, 1, 0, 0, 0);
    step("R3 FFh accepted", 1, 1, 8'hFF, 1, 0, 0, 0);
    step("R2 F0h accepted", 1, 1, 8'hF0, 1, 0, 0, 0);

    // R9: write in same cycle as an address frame uses old bytes
    step("R9 same-cycle write", 1, 1, 8'hF2, 1, 1, 0, 8'h00);
    step("R9 selection kept", 1, 0, 8'h44, 1, 0, 0, 0);
    step("R9 new byte now used", 1, 1, 8'h02, 1, 0, 0, 0);
    step("R4 data after hit", 1, 0, 8'h66, 1, 0, 0, 0);

    // R11: mixed random traffic
    for (int k = 0; k < 400; k++) begin
      logic [7:0] rd = $urandom;
      bit fv = ($urandom % 3) != 0;
      bit ft = ($urandom % 2) != 0;
      bit en = ($urandom % 5) != 0;
      bit we = ($urandom % 8) == 0;
      bit ws = ($urandom % 2) != 0;
      logic [7:0] wd = $urandom;
      if ($urandom % 2) rd = mOwn | mMask | rd[1:0];
      step("R11 random", fv, ft, rd, en, we, ws, wd);
    end
    idle("R11 quiet");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule